// File: doc/BRIEF.md
# Single-Accumulator Stored-Program Core with Index Register

This block is a small multi-cycle processor built around one accumulator (AC), one index register (IX) and a program counter (PC). It talks to a single synchronous memory that holds both the program and its data. Every 16-bit word is either data or an instruction. An instruction holds a 4-bit opcode in bits 15:12, an index-enable flag in bit 11 and an 11-bit address or immediate field in bits 10:0. A control FSM steps each instruction through a fetch cycle, an execute cycle and, for instructions that read an operand, a memory cycle. The core stops with a sticky halted flag when it meets the halt opcode.

Two styles of counted loop are supported. In the first, the program rewrites the address fields of its own instructions: a load-address instruction pulls the field of a word into AC, and a store-address instruction writes AC back into that field without touching the opcode bits. In the second, IX is loaded with a negative count. A combined test-and-increment branch walks IX up to zero, and indexed operands reach M[field + IX].

Top module: `acc_cpu`

## Requirements
- R1: While reset is high and after it is released, AC, IX and PC are zero and halted is low. The first access after release is a read of address 0.
- R2: The opcodes are HLT=0, LOAD=1, STORE=2, ADD=3, SUB=4, SHL=5, SHR=6, JUMP=7, JGE=8, LDADR=9, STADR=10, JZI=11, LDI=12, STI=13, INCI=14, and 15 is a no-op that only advances PC.
- R3: LOAD sets AC to M[ea] and STORE writes AC to M[ea]. ADD and SUB set AC to AC plus or minus M[ea], modulo 2^16.
- R4: SHL shifts AC left by one with a zero fill. SHR shifts AC right by one and keeps the sign bit.
- R5: JUMP sets PC to ea. JGE sets PC to ea when AC bit 15 is 0 and otherwise goes on to PC+1.
- R6: When bit 11 is set, ea is field + IX modulo 2^11 for LOAD, STORE, ADD, SUB, JUMP, JGE, LDADR and STADR. When bit 11 is clear, ea is the field. The IX instructions JZI, LDI, STI and INCI always use the bare field.
- R7: LDADR sets AC to bits 10:0 of M[ea], zero-extended to 16 bits.
- R8: STADR reads M[ea] and then writes it back to the same address. Bits 15:11 keep their old value and bits 10:0 take bits 10:0 of AC.
- R9: JZI sets PC to the field when IX is zero. Otherwise it adds one to IX and goes on to PC+1.
- R10: LDI loads bits 10:0 of M[field] into IX. STI writes IX sign-extended from bit 10 to M[field].
- R11: INCI adds the field to IX modulo 2^11 and leaves AC unchanged.
- R12: HLT sets halted at the end of its execute cycle. After that there are no memory accesses, PC is frozen, and halted stays set until reset.
- R13: Each instruction takes a fetch cycle (read at PC) and then an execute cycle. LOAD, ADD, SUB, LDADR, STADR and LDI add a third cycle. Read data arrives one cycle after the read. STADR writes in its third cycle, and a read and a write are never issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 11 | Memory word address |
| mem_rd_en | output | 1 | Read request; data arrives next cycle |
| mem_wr_en | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Registered read data |
| halted | output | 1 | Sticky halt flag |

## Verification
The bench runs three programs: the self-modifying vector add, the indexed vector add, and a directed sequence. The directed sequence takes SHR of a negative number, JGE on both signs, LDI truncation, STI sign extension in both polarities, INCI wrapping IX to zero, and STADR on a word whose upper bits are nonzero. A design that masked the wrong bits in STADR would corrupt the patched opcode, and the self-modifying loop would then run off into the wrong instructions. A JZI that incremented before testing would run the loop one element short. A logical SHR would turn 0x8005 into 0x4002 instead of 0xC002. Any extra or missing cycle shows up at once as a bus mismatch, because every access is compared cycle by cycle against a behavioural instruction model.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_HLT   = 4'd0,  OP_LOAD  = 4'd1,  OP_STORE = 4'd2,  OP_ADD  = 4'd3,
    OP_SUB   = 4'd4,  OP_SHL   = 4'd5,  OP_SHR   = 4'd6,  OP_JUMP = 4'd7,
    OP_JGE   = 4'd8,  OP_LDADR = 4'd9,  OP_STADR = 4'd10, OP_JZI  = 4'd11,
    OP_LDI   = 4'd12, OP_STI   = 4'd13, OP_INCI  = 4'd14, OP_NOP  = 4'd15
  } opcode_e;

  typedef enum logic [1:0] {S_FETCH, S_EXEC, S_MEM, S_HALT} cpu_state_e;

  // opcodes whose address field may be offset by IX
  function automatic logic op_indexed(opcode_e op);
    return op inside {OP_LOAD, OP_STORE, OP_ADD, OP_SUB, OP_JUMP, OP_JGE,
                      OP_LDADR, OP_STADR};
  endfunction

  // opcodes that need an operand read (third cycle)
  function automatic logic op_reads(opcode_e op);
    return op inside {OP_LOAD, OP_ADD, OP_SUB, OP_LDADR, OP_STADR, OP_LDI};
  endfunction
endpackage

// File: rtl/acc_cpu_agen.sv
module acc_cpu_agen
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  opcode_e             op,
  input  logic                xbit,
  input  logic [ADDR_W-1:0]   field,
  input  logic [ADDR_W-1:0]   ix,
  output logic [ADDR_W-1:0]   ea
);
  // R6: index offset only for the memory/jump group
  always_comb begin
    if (xbit && op_indexed(op)) ea = field + ix;
    else                        ea = field;
  end
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input  opcode_e             op,
  input  logic [DATA_W-1:0]   acc,
  input  logic [DATA_W-1:0]   opnd,
  output logic [DATA_W-1:0]   res
);
  localparam int HI_W = DATA_W - ADDR_W;

  always_comb begin
    case (op)
      OP_LOAD:  res = opnd;
      OP_ADD:   res = acc + opnd;
      OP_SUB:   res = acc - opnd;
      OP_SHL:   res = {acc[DATA_W-2:0], 1'b0};
      OP_SHR:   res = {acc[DATA_W-1], acc[DATA_W-1:1]};
      OP_LDADR: res = {{HI_W{1'b0}}, opnd[ADDR_W-1:0]};
      default:  res = acc;
    endcase
  end
endmodule

// File: rtl/acc_cpu_fsm.sv
module acc_cpu_fsm
  import acc_cpu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  opcode_e    dec_op,
  output cpu_state_e state
);
  cpu_state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      S_FETCH: nxt = S_EXEC;
      S_EXEC: begin
        if (dec_op == OP_HLT)     nxt = S_HALT;
        else if (op_reads(dec_op)) nxt = S_MEM;
        else                       nxt = S_FETCH;
      end
      S_MEM:   nxt = S_FETCH;
      default: nxt = S_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_FETCH;
    else     state <= nxt;
  end

  // R13: memory cycle is always followed by a fetch
  p_mem_then_fetch_r13: assert property (@(posedge clk) disable iff (rst)
    state == S_MEM |=> state == S_FETCH);
  // R12: halt state is never left without reset
  p_halt_sticky_r12: assert property (@(posedge clk) disable iff (rst)
    state == S_HALT |=> state == S_HALT);
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halted
);
  localparam int HI_W = DATA_W - ADDR_W;
  localparam logic [ADDR_W-1:0] A_ONE  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_ZERO = '0;

  cpu_state_e        st;
  opcode_e           dop, ir_op, alu_op;
  logic              xbit;
  logic [ADDR_W-1:0] fld, ea_c, ea_q;
  logic [ADDR_W-1:0] pc_q, ix_q;
  logic [DATA_W-1:0] ac_q, alu_res;
  logic              ac_we;

  assign dop  = opcode_e'(mem_rdata[DATA_W-1 -: OP_W]);
  assign xbit = mem_rdata[ADDR_W];
  assign fld  = mem_rdata[ADDR_W-1:0];

  acc_cpu_fsm u_fsm (.clk(clk), .rst(rst), .dec_op(dop), .state(st));

  acc_cpu_agen #(.ADDR_W(ADDR_W)) u_agen (
    .op(dop), .xbit(xbit), .field(fld), .ix(ix_q), .ea(ea_c));

  assign alu_op = (st == S_EXEC) ? dop : ir_op;

  acc_cpu_alu #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_alu (
    .op(alu_op), .acc(ac_q), .opnd(mem_rdata), .res(alu_res));

  assign ac_we = ((st == S_EXEC) && (dop inside {OP_SHL, OP_SHR})) ||
                 ((st == S_MEM) && (ir_op inside {OP_LOAD, OP_ADD, OP_SUB, OP_LDADR}));

  // memory port
  always_comb begin
    mem_rd_en = 1'b0;
    mem_wr_en = 1'b0;
    mem_addr  = pc_q;
    mem_wdata = ac_q;
    case (st)
      S_FETCH: mem_rd_en = 1'b1;
      S_EXEC: begin
        if (op_reads(dop)) begin
          mem_rd_en = 1'b1;
          mem_addr  = ea_c;
        end else if (dop == OP_STORE) begin
          mem_wr_en = 1'b1;
          mem_addr  = ea_c;
        end else if (dop == OP_STI) begin
          mem_wr_en = 1'b1;
          mem_addr  = fld;
          mem_wdata = {{HI_W{ix_q[ADDR_W-1]}}, ix_q};
        end
      end
      S_MEM: begin
        if (ir_op == OP_STADR) begin
          mem_wr_en = 1'b1;
          mem_addr  = ea_q;
          mem_wdata = {mem_rdata[DATA_W-1:ADDR_W], ac_q[ADDR_W-1:0]};
        end
      end
      default: ;
    endcase
  end

  // architectural registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ac_q   <= '0;
      ix_q   <= '0;
      pc_q   <= '0;
      ea_q   <= '0;
      ir_op  <= OP_NOP;
      halted <= 1'b0;
    end else begin
      if (ac_we) ac_q <= alu_res;
      if (st == S_EXEC) begin
        ir_op <= dop;
        ea_q  <= ea_c;
        pc_q  <= pc_q + A_ONE;
        case (dop)
          OP_HLT: begin
            pc_q   <= pc_q;
            halted <= 1'b1;
          end
          OP_JUMP: pc_q <= ea_c;
          OP_JGE:  if (!ac_q[DATA_W-1]) pc_q <= ea_c;
          OP_JZI: begin
            if (ix_q == A_ZERO) pc_q <= fld;
            else                ix_q <= ix_q + A_ONE;
          end
          OP_INCI: ix_q <= ix_q + fld;
          default: ;
        endcase
      end
      if ((st == S_MEM) && (ir_op == OP_LDI)) ix_q <= mem_rdata[ADDR_W-1:0];
    end
  end

  // R12: no bus traffic once halted
  p_halt_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!mem_rd_en && !mem_wr_en));
  // R12: PC frozen after halt
  p_halt_pc_r12: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(pc_q));
  // R13: port never reads and writes together
  p_port_excl_r13: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_en && mem_wr_en));
  // R8: the field write-back targets the word just read
  p_stadr_same_addr_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_en && st == S_MEM) |-> (mem_addr == $past(mem_addr)));
  // R11: index increment leaves AC alone
  p_inci_ac_r11: assert property (@(posedge clk) disable iff (rst)
    (st == S_EXEC && dop == OP_INCI) |=> $stable(ac_q));
  // R9: non-zero IX steps by one on the test-and-increment branch
  p_jzi_step_r9: assert property (@(posedge clk) disable iff (rst)
    (st == S_EXEC && dop == OP_JZI && ix_q != A_ZERO) |=> (ix_q == $past(ix_q) + A_ONE));
endmodule

// File: tb/acc_cpu_bench.sv
module acc_cpu_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] mem_addr;
  logic        mem_rd_en, mem_wr_en, halted;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;

  logic [15:0] bmem [0:2047];
  logic [15:0] mm   [0:2047];

  typedef struct {
    logic        rd;
    logic        we;
    logic [10:0] addr;
    logic [15:0] wdata;
    logic        hl;
    int          req;
  } ev_t;
  ev_t evq[$];

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  acc_cpu u_acc_cpu (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .halted(halted));

  // synchronous memory, one-cycle read latency (R13)
  always @(posedge clk) begin
    if (mem_wr_en) bmem[mem_addr] <= mem_wdata;
    if (mem_rd_en) mem_rdata <= bmem[mem_addr];
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got no finish, expected finish within 100000 cycles");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // word builder, encoding per R2: op[15:12] x[11] field[10:0]
  function automatic logic [15:0] w(int op, int x, int f);
    return {op[3:0], x[0], f[10:0]};
  endfunction

  function automatic logic [15:0] av(int i); return 16'(100 * i + 7); endfunction
  function automatic logic [15:0] bv(int i); return 16'(16'hFF00 + 3 * i); endfunction

  task automatic push(logic rd, logic we, logic [10:0] a, logic [15:0] d, logic hl, int rq);
    ev_t e;
    e.rd = rd; e.we = we; e.addr = a; e.wdata = d; e.hl = hl; e.req = rq;
    evq.push_back(e);
  endtask

  // behavioural instruction model producing the expected bus per cycle
  task automatic run_model();
    logic [15:0] ac = '0, t, wd;
    logic [10:0] ix = '0, pc = '0, f, ea;
    logic [3:0]  op;
    logic        xi;
    int          rq;
    evq.delete();
    for (int g = 0; g < 4000; g++) begin
      wd = mm[pc]; op = wd[15:12]; f = wd[10:0];
      xi = wd[11] && (op inside {1, 2, 3, 4, 7, 8, 9, 10});
      ea = xi ? f + ix : f;
      push(1'b1, 1'b0, pc, '0, 1'b0, (g == 0) ? 1 : 13);  // R1 first fetch, R13 fetch
      case (op)
        1, 2, 3, 4: rq = xi ? 6 : 3;
        5, 6:       rq = 4;
        7, 8:       rq = xi ? 6 : 5;
        9:          rq = 7;
        10:         rq = 8;
        11:         rq = 9;
        12, 13:     rq = 10;
        14:         rq = 11;
        default:    rq = 12;
      endcase
      case (op)
        0: begin push(1'b0, 1'b0, '0, '0, 1'b0, 12); return; end
        1: begin push(1'b1, 1'b0, ea, '0, 1'b0, rq); push(1'b0, 1'b0, '0, '0, 1'b0, 13);
                 ac = mm[ea]; pc++; end
        2: begin push(1'b0, 1'b1, ea, ac, 1'b0, rq); mm[ea] = ac; pc++; end
        3: begin push(1'b1, 1'b0, ea, '0, 1'b0, rq); push(1'b0, 1'b0, '0, '0, 1'b0, 13);
                 ac = ac + mm[ea]; pc++; end
        4: begin push(1'b1, 1'b0, ea, '0, 1'b0, rq); push(1'b0, 1'b0, '0, '0, 1'b0, 13);
                 ac = ac - mm[ea]; pc++; end
        5: begin push(1'b0, 1'b0, '0, '0, 1'b0, rq); ac = ac * 2; pc++; end
        6: begin push(1'b0, 1'b0, '0, '0, 1'b0, rq); ac = 16'($signed(ac) >>> 1); pc++; end
        7: begin push(1'b0, 1'b0, '0, '0, 1'b0, rq); pc = ea; end
        8: begin push(1'b0, 1'b0, '0, '0, 1'b0, rq);
                 if ($signed(ac) >= 0) pc = ea; else pc++; end
        9: begin push(1'b1, 1'b0, ea, '0, 1'b0, rq); push(1'b0, 1'b0, '0, '0, 1'b0, 13);
                 ac = {5'b0, mm[ea][10:0]}; pc++; end
        10: begin t = {mm[ea][15:11], ac[10:0]};
                  push(1'b1, 1'b0, ea, '0, 1'b0, rq); push(1'b0, 1'b1, ea, t, 1'b0, rq);
                  mm[ea] = t; pc++; end
        11: begin push(1'b0, 1'b0, '0, '0, 1'b0, rq);
                  if (ix == 0) pc = f; else begin ix++; pc++; end end
        12: begin push(1'b1, 1'b0, f, '0, 1'b0, rq); push(1'b0, 1'b0, '0, '0, 1'b0, 13);
                  ix = mm[f][10:0]; pc++; end
        13: begin t = 16'($signed(ix)); push(1'b0, 1'b1, f, t, 1'b0, rq); mm[f] = t; pc++; end
        14: begin push(1'b0, 1'b0, '0, '0, 1'b0, rq); ix = ix + f; pc++; end
        default: begin push(1'b0, 1'b0, '0, '0, 1'b0, rq); pc++; end
      endcase
    end
  endtask

  task automatic build(int p);
    for (int a = 0; a < 2048; a++) bmem[a] = '0;
    if (p == 0) begin  // self-modifying vector add, n=4
      bmem[100] = 16'hFFFC; bmem[101] = 16'd1;
      bmem[0] = w(1, 0, 100);  bmem[1] = w(8, 0, 17);  bmem[2] = w(3, 0, 101);
      bmem[3] = w(2, 0, 100);  bmem[4] = w(1, 0, 200); bmem[5] = w(3, 0, 300);
      bmem[6] = w(2, 0, 400);
      for (int k = 0; k < 3; k++) begin
        bmem[7 + 3 * k] = w(9, 0, 4 + k);
        bmem[8 + 3 * k] = w(3, 0, 101);
        bmem[9 + 3 * k] = w(10, 0, 4 + k);
      end
      bmem[16] = w(7, 0, 0);   bmem[17] = w(0, 0, 0);
    end else if (p == 1) begin  // indexed vector add
      bmem[100] = 16'hFFFC;
      bmem[0] = w(12, 0, 100); bmem[1] = w(11, 0, 6);  bmem[2] = w(1, 1, 203);
      bmem[3] = w(3, 1, 303);  bmem[4] = w(2, 1, 403); bmem[5] = w(7, 0, 1);
      bmem[6] = w(0, 0, 0);
    end else begin  // directed corner cases
      bmem[100] = 16'h8005; bmem[101] = 16'h1234; bmem[102] = 16'h7ABC; bmem[103] = 16'hF00A;
      bmem[0]  = w(1, 0, 100);  bmem[1]  = w(6, 0, 0);    bmem[2]  = w(2, 0, 120);
      bmem[3]  = w(5, 0, 0);    bmem[4]  = w(2, 0, 121);  bmem[5]  = w(8, 0, 20);
      bmem[6]  = w(4, 0, 101);  bmem[7]  = w(8, 0, 9);    bmem[8]  = w(2, 0, 122);
      bmem[9]  = w(12, 0, 102); bmem[10] = w(13, 0, 123); bmem[11] = w(14, 0, 16'h500);
      bmem[12] = w(13, 0, 124); bmem[13] = w(2, 0, 125);  bmem[14] = w(9, 0, 103);
      bmem[15] = w(3, 0, 101);  bmem[16] = w(10, 0, 103); bmem[17] = w(15, 0, 0);
      bmem[18] = w(14, 0, 16'h44); bmem[19] = w(11, 0, 21); bmem[20] = w(0, 0, 0);
      bmem[21] = w(14, 0, 3);   bmem[22] = w(1, 1, 100);  bmem[23] = w(2, 1, 127);
      bmem[24] = w(11, 0, 20);  bmem[25] = w(13, 0, 126); bmem[26] = w(0, 0, 0);
    end
    if (p != 2)
      for (int i = 0; i < 4; i++) begin bmem[200 + i] = av(i); bmem[300 + i] = bv(i); end
    for (int a = 0; a < 2048; a++) mm[a] = bmem[a];
  endtask

  task automatic cmp_ev(ev_t e);
    bit bad;
    n_cmp++;
    bad = (mem_rd_en !== e.rd) || (mem_wr_en !== e.we) || (halted !== e.hl);
    if (e.rd || e.we) bad = bad || (mem_addr !== e.addr);
    if (e.we) bad = bad || (mem_wdata !== e.wdata);
    if (bad) begin
      n_bad++;
      $display("FAIL R%0d bus: got rd=%0b we=%0b addr=%0h wd=%0h hl=%0b, expected rd=%0b we=%0b addr=%0h wd=%0h hl=%0b",
               e.req, mem_rd_en, mem_wr_en, mem_addr, mem_wdata, halted,
               e.rd, e.we, e.addr, e.wdata, e.hl);
    end
  endtask

  task automatic chk(string rq, logic [15:0] got, logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h, expected %0h", rq, got, exp);
    end
  endtask

  initial begin
    ev_t e;
    for (int p = 0; p < 3; p++) begin
      rst = 1'b1;
      build(p);
      run_model();
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 halted in reset", {15'b0, halted}, 16'h0);
      rst = 1'b0;
      while (evq.size() > 0) begin
        #2;
        e = evq.pop_front();
        cmp_ev(e);
        @(negedge clk);
      end
      // R12: quiet and halted afterwards
      e.rd = 1'b0; e.we = 1'b0; e.addr = '0; e.wdata = '0; e.hl = 1'b1; e.req = 12;
      repeat (3) begin #2; cmp_ev(e); @(negedge clk); end
      if (p < 2)
        for (int i = 0; i < 4; i++)
          chk(p == 0 ? "R3 R8 self-mod sum" : "R6 R9 R10 indexed sum", bmem[400 + i], av(i) + bv(i));
      if (p == 0) begin
        chk("R3 loop count", bmem[100], 16'h0000);
        chk("R8 patched opcode kept", bmem[4], w(1, 0, 204));
      end
      if (p == 2) begin
        chk("R4 SHR sign", bmem[120], 16'hC002);
        chk("R4 SHL", bmem[121], 16'h8004);
        chk("R5 JGE taken skips store", bmem[122], 16'h0000);
        chk("R10 STI positive", bmem[123], 16'h02BC);
        chk("R10 STI negative", bmem[124], 16'hFFBC);
        chk("R11 AC kept over INCI", bmem[125], 16'h6DD0);
        chk("R7 R8 STADR merge", bmem[103], 16'hF23E);
        chk("R6 indexed load/store", bmem[130], 16'hF23E);
        chk("R9 JZI increments", bmem[126], 16'h0004);
        chk("R2 no-op word intact", bmem[17], 16'hF000);
      end
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule